// File: doc/BRIEF.md
# Nibble-Multiplexed Converter Word Link

This block is the digital end of a link to an analog converter device. Sample words are 16 bits wide, but the pins between the two devices are only 4 bits wide. Each word therefore crosses in four consecutive master-clock cycles, called slots 0 to 3. A one-cycle marker flags slot 0 of every word. In slot c, pin k of a nibble bus carries word bit 4c+k, so bits 0..3 travel first and bits 12..15 travel last. Alongside each nibble bus a single side wire carries one general-purpose test bit per slot.

The transmit half has a free-running slot counter. In slot 0 it takes a data word, an echo word and four test bits from its inputs and holds them for the whole word. It sends the data word on one nibble bus and the echo word on a second nibble bus, with identical slot timing. Its own word marker goes out with slot 0.

The receive half follows the incoming marker. It rebuilds a 16-bit word from four nibbles and four test bits from the side input, then presents them with a one-cycle valid pulse. The marker must recur exactly every four cycles. A marker in the wrong slot, or a missing marker, sets a sticky alignment-error flag. An early marker also realigns the receiver to itself. At a 35.328 MHz master clock the link carries 8.832 M words per second in each direction.

Top module: `nibble_word_link`

## Requirements
- R1: In the transmit output cycle where `tx_mark` is high, the slot index c is 0; in the following three cycles c is 1, 2 and 3. In slot c, `tx_nib[k]` equals bit 4c+k of the data word and `tx_enib[k]` equals bit 4c+k of the echo word.
- R2: `tx_take` is high in the first cycle after reset and in every fourth cycle after that. The word and test bits are sampled at the rising edge where `tx_take` is high, and their four slots appear in the next four cycles. Input values in any other cycle have no effect on the outputs.
- R3: In transmit slot c, `tx_tbit` equals bit c of the sampled `tx_tbits`.
- R4: `tx_mark` is high for exactly one cycle out of every four.
- R5: The receive cycle with `rx_mark` high is slot 0, and each following cycle is the next slot, modulo 4. The nibble received in slot c becomes bits 4c+k of `rx_word`.
- R6: The side bit received in slot c becomes `rx_tbits[c]`.
- R7: `rx_valid` is a single-cycle pulse in the cycle after slot 3 is captured. `rx_word` and `rx_tbits` hold their values until the next pulse.
- R8: After reset, no `rx_valid` pulse occurs before the first `rx_mark`.
- R9: An `rx_mark` that arrives in slot 1, 2 or 3 after the first marker sets `align_err` in the next cycle. That cycle becomes slot 0, and the partial word is dropped. Correctly spaced markers never set the flag.
- R10: A slot 0 without `rx_mark` after the first marker sets `align_err`. Counting continues, and that word is still delivered.
- R11: Reset clears every output register, including `align_err`. Apart from reset, `align_err` never falls once set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 16 | Data word to transmit, sampled when `tx_take` is high |
| tx_echo | input | 16 | Echo word to transmit, sampled with `tx_data` |
| tx_tbits | input | 4 | Test bits to transmit, one per slot |
| tx_take | output | 1 | High in the cycle whose rising edge samples the transmit inputs |
| tx_mark | output | 1 | Transmit word marker, high in slot 0 |
| tx_nib | output | 4 | Data nibble bus |
| tx_enib | output | 4 | Echo nibble bus |
| tx_tbit | output | 1 | Transmit side test bit |
| rx_mark | input | 1 | Receive word marker, high in slot 0 |
| rx_nib | input | 4 | Received nibble bus |
| rx_tbit | input | 1 | Received side test bit |
| rx_word | output | 16 | Last completed received word |
| rx_tbits | output | 4 | Test bits of the last completed word |
| rx_valid | output | 1 | One-cycle pulse when a word completes |
| align_err | output | 1 | Sticky receive alignment error |

## Verification
Two functions can act in the same cycle: realignment and word assembly. When an early marker arrives, that one cycle both raises the alignment error and becomes slot 0 of the next word. The bench provokes this by sending a two-slot partial word and then a full word. The check passes only if the next delivered word equals the new word, no word is produced from the partial fragment, and the flag is set. A missing marker likewise makes flagging coincide with continued assembly; that case is judged by the flag rising while the word is still delivered intact.

// File: rtl/nwl_pkg.sv
`timescale 1ns/1ps
package nwl_pkg;
    localparam int WORD_W = 16;
    localparam int NIB_W  = 4;
    localparam int SLOTS  = WORD_W / NIB_W;
    localparam int CNT_W  = $clog2(SLOTS);

    typedef logic [CNT_W-1:0]  slot_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SLOTS-1:0]  tbit_t;

    localparam slot_t LAST_SLOT = slot_t'(SLOTS - 1);

    typedef struct packed {
        word_t data;
        word_t echo;
        tbit_t tbits;
    } tx_frame_t;

    typedef struct packed {
        word_t data;
        tbit_t tbits;
    } rx_frame_t;

    function automatic slot_t slot_next(slot_t s);
        return (s == LAST_SLOT) ? '0 : slot_t'(s + 1'b1);
    endfunction

    function automatic nib_t nib_of(word_t w, slot_t s);
        return w[s*NIB_W +: NIB_W];
    endfunction
endpackage

// File: rtl/nwl_tx_serializer.sv
`timescale 1ns/1ps
module nwl_tx_serializer
    import nwl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t data_in,
    input  word_t echo_in,
    input  tbit_t tbits_in,
    output logic  take,
    output logic  mark,
    output nib_t  nib,
    output nib_t  enib,
    output logic  tbit
);
    slot_t     cnt;
    tx_frame_t hold;
    tx_frame_t src;

    // Slot 0 draws from the live inputs so the fresh word is sent without delay.
    always_comb begin
        if (cnt == '0) begin
            src.data  = data_in;
            src.echo  = echo_in;
            src.tbits = tbits_in;
        end else begin
            src = hold;
        end
    end

    assign take = (cnt == '0) && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            hold <= '0;
            mark <= 1'b0;
            nib  <= '0;
            enib <= '0;
            tbit <= 1'b0;
        end else begin
            cnt  <= slot_next(cnt);
            if (cnt == '0) hold <= src;
            mark <= (cnt == '0);
            nib  <= nib_of(src.data, cnt);
            enib <= nib_of(src.echo, cnt);
            tbit <= src.tbits[cnt];
        end
    end
endmodule

// File: rtl/nwl_align_monitor.sv
`timescale 1ns/1ps
module nwl_align_monitor
    import nwl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mark,
    output slot_t cur,
    output logic  locked,
    output logic  err
);
    slot_t slot;

    // A marker forces the present cycle to slot 0 (realignment).
    assign cur = mark ? '0 : slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot   <= '0;
            locked <= 1'b0;
            err    <= 1'b0;
        end else begin
            slot <= slot_next(cur);
            if (mark) locked <= 1'b1;
            if (locked && (mark != (slot == '0))) err <= 1'b1;
        end
    end
endmodule

// File: rtl/nwl_rx_assembler.sv
`timescale 1ns/1ps
module nwl_rx_assembler
    import nwl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_t     cur,
    input  logic      locked,
    input  nib_t      nib,
    input  logic      tbit,
    output rx_frame_t frame,
    output logic      valid
);
    word_t acc, acc_n;
    tbit_t tacc, tacc_n;

    always_comb begin
        acc_n  = acc;
        tacc_n = tacc;
        acc_n[cur*NIB_W +: NIB_W] = nib;
        tacc_n[cur] = tbit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            tacc  <= '0;
            frame <= '0;
            valid <= 1'b0;
        end else begin
            acc   <= acc_n;
            tacc  <= tacc_n;
            valid <= locked && (cur == LAST_SLOT);
            if (locked && (cur == LAST_SLOT)) begin
                frame.data  <= acc_n;
                frame.tbits <= tacc_n;
            end
        end
    end
endmodule

// File: rtl/nibble_word_link.sv
`timescale 1ns/1ps
module nibble_word_link
    import nwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] tx_data,
    input  logic [WORD_W-1:0] tx_echo,
    input  logic [SLOTS-1:0]  tx_tbits,
    output logic              tx_take,
    output logic              tx_mark,
    output logic [NIB_W-1:0]  tx_nib,
    output logic [NIB_W-1:0]  tx_enib,
    output logic              tx_tbit,
    input  logic              rx_mark,
    input  logic [NIB_W-1:0]  rx_nib,
    input  logic              rx_tbit,
    output logic [WORD_W-1:0] rx_word,
    output logic [SLOTS-1:0]  rx_tbits,
    output logic              rx_valid,
    output logic              align_err
);
    slot_t     rx_cur;
    logic      rx_locked;
    rx_frame_t rx_frame;

    nwl_tx_serializer u_tx (
        .clk(clk), .rst(rst),
        .data_in(tx_data), .echo_in(tx_echo), .tbits_in(tx_tbits),
        .take(tx_take), .mark(tx_mark),
        .nib(tx_nib), .enib(tx_enib), .tbit(tx_tbit)
    );

    nwl_align_monitor u_align (
        .clk(clk), .rst(rst), .mark(rx_mark),
        .cur(rx_cur), .locked(rx_locked), .err(align_err)
    );

    nwl_rx_assembler u_rx (
        .clk(clk), .rst(rst), .cur(rx_cur), .locked(rx_locked),
        .nib(rx_nib), .tbit(rx_tbit),
        .frame(rx_frame), .valid(rx_valid)
    );

    assign rx_word  = rx_frame.data;
    assign rx_tbits = rx_frame.tbits;
endmodule

// File: rtl/nwl_link_checker.sv
`timescale 1ns/1ps
module nwl_link_checker (
    input logic clk,
    input logic rst,
    input logic rx_mark,
    input logic tx_take,
    input logic tx_mark,
    input logic rx_valid,
    input logic align_err
);
    // Independent gap counter: 1 in the cycle after a marker, saturating at 7.
    logic [2:0] gap;
    logic       seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (rx_mark) begin
            gap  <= 3'd1;
            seen <= 1'b1;
        end else if (gap != 3'd7) begin
            gap <= gap + 3'd1;
        end
    end

    p_take_then_mark_r2: assert property (@(posedge clk) disable iff (rst)
        tx_take |=> tx_mark);

    p_mark_period_r4: assert property (@(posedge clk) disable iff (rst)
        tx_mark |=> !tx_mark ##1 !tx_mark ##1 !tx_mark ##1 tx_mark);

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_valid_after_slot3_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !align_err) |-> $past(seen && !rx_mark && gap == 3'd3));

    p_no_valid_unlocked_r8: assert property (@(posedge clk) disable iff (rst)
        !seen |-> !rx_valid);

    p_early_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (seen && rx_mark && gap != 3'd4) |=> align_err);

    p_missing_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (seen && !rx_mark && gap == 3'd4) |=> align_err);

    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        align_err |=> align_err);
endmodule

bind nibble_word_link nwl_link_checker i_nwl_chk (
    .clk(clk), .rst(rst), .rx_mark(rx_mark), .tx_take(tx_take),
    .tx_mark(tx_mark), .rx_valid(rx_valid), .align_err(align_err)
);

// File: tb/test_nibble_word_link.sv
`timescale 1ns/1ps
module test_nibble_word_link;
    import nwl_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tx_data = '0, tx_echo = '0;
    logic [3:0]  tx_tbits = '0;
    logic        tx_take, tx_mark, tx_tbit;
    logic [3:0]  tx_nib, tx_enib;
    logic        rx_mark = 1'b0;
    logic [3:0]  rx_nib = '0;
    logic        rx_tbit = 1'b0;
    logic [15:0] rx_word;
    logic [3:0]  rx_tbits;
    logic        rx_valid, align_err;

    always #2 clk = ~clk;

    nibble_word_link i_nibble_word_link (
        .clk(clk), .rst(rst),
        .tx_data(tx_data), .tx_echo(tx_echo), .tx_tbits(tx_tbits),
        .tx_take(tx_take), .tx_mark(tx_mark), .tx_nib(tx_nib),
        .tx_enib(tx_enib), .tx_tbit(tx_tbit),
        .rx_mark(rx_mark), .rx_nib(rx_nib), .rx_tbit(rx_tbit),
        .rx_word(rx_word), .rx_tbits(rx_tbits), .rx_valid(rx_valid),
        .align_err(align_err)
    );

    int errors = 0;
    int checks = 0;
    int vcount = 0;
    bit armed  = 0;
    bit done   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int          m_tcnt, m_pos, s;
    bit          m_lock;
    logic [15:0] m_hd, m_he, m_acc;
    logic [3:0]  m_ht, m_tacc;
    logic [3:0]  e_nib, e_enib;
    logic        e_tbit, e_mark, e_valid, e_err;
    logic [15:0] e_word;
    logic [3:0]  e_tbits;

    always @(posedge clk) begin
        if (rst) begin
            m_tcnt = 0; m_pos = 0; m_lock = 0;
            m_hd = '0; m_he = '0; m_ht = '0; m_acc = '0; m_tacc = '0;
            e_nib = '0; e_enib = '0; e_tbit = 0; e_mark = 0;
            e_valid = 0; e_err = 0; e_word = '0; e_tbits = '0;
        end else begin
            if (m_tcnt == 0) begin
                m_hd = tx_data; m_he = tx_echo; m_ht = tx_tbits;
            end
            e_nib  = m_hd[4*m_tcnt +: 4];
            e_enib = m_he[4*m_tcnt +: 4];
            e_tbit = m_ht[m_tcnt];
            e_mark = (m_tcnt == 0);
            m_tcnt = (m_tcnt + 1) % 4;

            s = rx_mark ? 0 : m_pos;
            if (m_lock && (rx_mark != (m_pos == 0))) e_err = 1;
            m_acc[4*s +: 4] = rx_nib;
            m_tacc[s] = rx_tbit;
            e_valid = m_lock && (s == 3);
            if (e_valid) begin
                e_word = m_acc; e_tbits = m_tacc;
            end
            if (rx_mark) m_lock = 1;
            m_pos = (s + 1) % 4;
        end
        armed = 1;
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            chk("R1 data nibble", tx_nib, e_nib);
            chk("R1 echo nibble", tx_enib, e_enib);
            chk("R2 take", tx_take, (!rst && m_tcnt == 0));
            chk("R3 tx test bit", tx_tbit, e_tbit);
            chk("R4 tx mark", tx_mark, e_mark);
            chk("R5 rx word", rx_word, e_word);
            chk("R6 rx test bits", rx_tbits, e_tbits);
            chk("R7 rx valid", rx_valid, e_valid);
            chk("R9 align flag", align_err, e_err);
            if (rx_valid) vcount++;
        end
    end

    // Transmit stimulus changes every cycle; only slot-0 values may matter (R2).
    initial begin
        forever begin
            @(negedge clk); #1;
            tx_data  = 16'($urandom);
            tx_echo  = 16'($urandom);
            tx_tbits = 4'($urandom);
        end
    end

    task automatic send_word(input logic [15:0] w, input logic [3:0] t,
                             input bit with_mark, input int nslots);
        for (int c = 0; c < nslots; c++) begin
            rx_mark = (c == 0) && with_mark;
            rx_nib  = w[4*c +: 4];
            rx_tbit = t[c];
            @(negedge clk); #1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            rx_mark = 0;
            rx_nib  = 4'($urandom);
            rx_tbit = 1'($urandom);
            @(negedge clk); #1;
        end
    endtask

    task automatic do_reset(input int n);
        rst = 1; rx_mark = 0;
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    logic [15:0] pat_w [6] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h1234, 16'h8001, 16'h7E18};
    logic [3:0]  pat_t [6] = '{4'h0, 4'hF, 4'h5, 4'hA, 4'h9, 4'h6};

    initial begin
        repeat (3) begin @(negedge clk); #1; end
        chk("R11 reset valid", rx_valid, 0);
        chk("R11 reset flag", align_err, 0);
        chk("R11 reset mark", tx_mark, 0);
        chk("R11 reset word", rx_word, 0);
        rst = 0;
        vcount = 0;
        idle(7);
        chk("R8 no valid before first marker", vcount, 0);

        for (int i = 0; i < 16; i++) begin
            logic [15:0] w;
            logic [3:0]  t;
            w = (i < 6) ? pat_w[i] : 16'($urandom);
            t = (i < 6) ? pat_t[i] : 4'($urandom);
            send_word(w, t, 1, 4);
            chk("R5 word mapping", rx_word, w);
            chk("R6 test bit slots", rx_tbits, t);
            chk("R7 pulse after slot 3", rx_valid, 1);
        end
        chk("R9 no flag on regular markers", align_err, 0);

        send_word(16'hBEEF, 4'h3, 1, 2);
        send_word(16'hC0DE, 4'hC, 1, 4);
        chk("R9 early marker flagged", align_err, 1);
        chk("R9 realigned word", rx_word, 16'hC0DE);
        chk("R9 realigned test bits", rx_tbits, 4'hC);

        do_reset(2);
        chk("R11 flag cleared by reset", align_err, 0);
        rst = 0;
        for (int i = 0; i < 3; i++) send_word(16'($urandom), 4'($urandom), 1, 4);
        chk("R10 no flag before missing marker", align_err, 0);
        send_word(16'h5AC3, 4'h9, 0, 4);
        chk("R10 missing marker flagged", align_err, 1);
        chk("R10 word still delivered", rx_word, 16'h5AC3);
        for (int i = 0; i < 4; i++) send_word(16'($urandom), 4'($urandom), 1, 4);
        chk("R11 flag stays set", align_err, 1);
        idle(4);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule